// File: doc/BRIEF.md
# Self-Configuring Parallel Host Bus Adapter

This block is the slave end of an 8-bit parallel host bus that reaches a 16-location register space. It needs no configuration register. It reads the bus style from the latch-enable pin. If that pin is held high, one control pin is an active-low data strobe and the other gives the direction (high means read). If the pin is held low, the two control pins are separate active-low read and write strobes. If the pin toggles, the address arrives on the low data lines, is latched on the falling latch edge, and separate read and write strobes follow.

Every host pin is brought into the system clock through a two-stage synchronizer. Each host access becomes one internal write pulse, or a read that drives data together with an output-enable flag, which stands in for releasing the bus to high impedance. A small register file sits behind the interface:

- locations 0 to 3 are read-only;
- locations 4 to 11 are read/write;
- locations 12 to 15 are write-only.

Top module: `host_bus_adapter`

## Requirements
- R1: After `rst_ni` is released, `data_oe_o` is low and every read/write location (4 to 11) reads back 0x00.
- R2: While `ale_i` stays high, `ctl_a_i` is an active-low data strobe and `ctl_b_i` gives the direction: 1 is a read and 0 is a write.
- R3: While `ale_i` stays low, `ctl_a_i` is an active-low read strobe and `ctl_b_i` is an active-low write strobe.
- R4: Once two or more `ale_i` edges have been seen since reset, the multiplexed style is chosen and kept until the next reset. In that style the register address is taken from `data_i[3:0]` on the falling edge of `ale_i`.
- R5: In the demultiplexed styles, `addr_i` is sampled when the strobe starts. Later changes to `addr_i` during the same strobe have no effect on that access.
- R6: Each write access produces exactly one internal write. The write happens when the write strobe is released, or when the data strobe is released with the direction low. It stores the last `data_i` value seen while the write was active.
- R7: Locations 0 to 3 always read as 0xC0 OR'd with the address, and writes to them are ignored. Locations 12 to 15 read as 0x00. Locations 4 to 11 return the last value written.
- R8: `data_oe_o` is high only while `cs_ni` is low and a read is active. With `cs_ni` high, no strobe causes a write or drives data.
- R9: While `host_rst_i` is high, the interface returns to idle and clears its style detection. When it is released, the style is chosen again from the `ale_i` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| host_rst_i | input | 1 | Host reset pin, active high, asynchronous to the clock |
| cs_ni | input | 1 | Active-low chip select |
| ale_i | input | 1 | Address latch enable and bus-style selector |
| ctl_a_i | input | 1 | Data strobe or read strobe, active low |
| ctl_b_i | input | 1 | Direction line or write strobe |
| addr_i | input | 4 | Register address in the demultiplexed styles |
| data_i | input | 8 | Bus data in; carries the address in the multiplexed style |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Read data drive enable; low means the bus is released |

## Verification
In the separate-strobe style, the write pulse that follows a write strobe release can fall in the same cycle as the start of a read strobe. The bench provokes this by raising the write strobe and lowering the read strobe on the same clock edge, at the same address. It then requires the read to return the newly written value while the strobe is held, and requires that exactly one write took effect. A second case changes the address pins in the middle of a strobe, which puts a new address on the pins during an ongoing access. The bench judges it by requiring that the read data still come from the address seen when the strobe began.

// File: rtl/hba_pkg.sv
package hba_pkg;
  typedef enum logic [1:0] {
    MODE_STRB_DIR = 2'd0,
    MODE_SEP_STRB = 2'd1,
    MODE_MUXED    = 2'd2
  } bus_mode_e;
endpackage

// File: rtl/hba_sync.sv
module hba_sync #(
  parameter int         W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/hba_mode_det.sv
module hba_mode_det
  import hba_pkg::*;
#(
  parameter int EDGE_MIN = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hrst_i,
  input  logic      ale_i,
  output bus_mode_e mode_o
);
  localparam int CW = $clog2(EDGE_MIN + 1);

  logic          ale_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q <= 1'b0;
      cnt_q <= '0;
    end else if (hrst_i) begin
      ale_q <= ale_i;  // no edge counted across host reset
      cnt_q <= '0;
    end else begin
      ale_q <= ale_i;
      if (ale_i != ale_q && cnt_q < CW'(EDGE_MIN)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (cnt_q >= CW'(EDGE_MIN)) mode_o = MODE_MUXED;
    else if (ale_i)             mode_o = MODE_STRB_DIR;
    else                        mode_o = MODE_SEP_STRB;
  end

  assert_mux_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == MODE_MUXED && !hrst_i) |=> mode_o == MODE_MUXED);

  assert_hrst_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrst_i |=> mode_o != MODE_MUXED);
endmodule

// File: rtl/hba_access.sv
module hba_access
  import hba_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hrst_i,
  input  bus_mode_e     mode_i,
  input  logic          cs_n_i,
  input  logic          ctl_a_i,
  input  logic          ctl_b_i,
  input  logic          ale_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          rd_act_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic          sel, strb, rd_raw, wr_raw, strb_act, wr_act;
  logic          strb_q, wr_act_q, ale_q, start, ale_fall, demux;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  assign sel = !cs_n_i && !hrst_i;

  always_comb begin
    if (mode_i == MODE_STRB_DIR) begin
      strb   = !ctl_a_i;
      rd_raw = !ctl_a_i && ctl_b_i;
      wr_raw = !ctl_a_i && !ctl_b_i;
    end else begin
      strb   = !ctl_a_i || !ctl_b_i;
      rd_raw = !ctl_a_i;
      wr_raw = !ctl_b_i;
    end
  end

  assign strb_act = sel && strb;
  assign wr_act   = sel && wr_raw;
  assign demux    = mode_i != MODE_MUXED;
  assign start    = strb_act && !strb_q;
  assign ale_fall = ale_q && !ale_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strb_q   <= 1'b0;
      wr_act_q <= 1'b0;
      ale_q    <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
    end else if (hrst_i) begin
      strb_q   <= 1'b0;
      wr_act_q <= 1'b0;
      ale_q    <= ale_i;
      addr_q   <= '0;
    end else begin
      strb_q   <= strb_act;
      wr_act_q <= wr_act;
      ale_q    <= ale_i;
      if (wr_act) wdata_q <= data_i;
      if (demux && start)  addr_q <= addr_i;
      else if (ale_fall)   addr_q <= data_i[AW-1:0];
    end
  end

  assign rd_act_o  = sel && rd_raw;
  assign rd_addr_o = (demux && start) ? addr_i : addr_q;
  assign wr_o      = wr_act_q && !wr_act && !hrst_i;
  assign wr_addr_o = addr_q;
  assign wr_data_o = wdata_q;

  assert_single_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |=> !wr_o);

  assert_addr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (demux && strb_act && strb_q && !ale_fall && !hrst_i) |=> $stable(addr_q));
endmodule

// File: rtl/hba_regfile.sv
module hba_regfile #(
  parameter int          AW       = 4,
  parameter int          DW       = 8,
  parameter int          RO_LAST  = 3,
  parameter int          WO_FIRST = 12,
  parameter logic [DW-1:0] RO_TAG = 8'hC0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] view [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_loc
    if (i <= RO_LAST) begin : g_ro
      assign view[i] = RO_TAG | DW'(i);
    end else if (i >= WO_FIRST) begin : g_wo
      assign view[i] = '0;  // accepted, not visible on reads
    end else begin : g_rw
      logic [DW-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           q <= '0;
        else if (we_i && waddr_i == AW'(i))    q <= wdata_i;
      end
      assign view[i] = q;
    end
  end

  assign rdata_o = view[raddr_i];
endmodule

// File: rtl/host_bus_adapter.sv
module host_bus_adapter
  import hba_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int EDGE_MIN = 2,
  parameter int RO_LAST  = 3,
  parameter int WO_FIRST = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_rst_i,
  input  logic          cs_ni,
  input  logic          ale_i,
  input  logic          ctl_a_i,
  input  logic          ctl_b_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  localparam int SW = 5 + AW + DW;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, 1'b1, 1'b1, {AW{1'b0}}, {DW{1'b0}}};

  logic          hrst_s, cs_n_s, ale_s, ctl_a_s, ctl_b_s;
  logic [AW-1:0] addr_s, rd_addr, wr_addr;
  logic [DW-1:0] data_s, wr_data;
  logic          rd_act, wr;
  bus_mode_e     mode;

  hba_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({host_rst_i, cs_ni, ale_i, ctl_a_i, ctl_b_i, addr_i, data_i}),
    .q_o   ({hrst_s, cs_n_s, ale_s, ctl_a_s, ctl_b_s, addr_s, data_s})
  );

  hba_mode_det #(.EDGE_MIN(EDGE_MIN)) u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hrst_i(hrst_s),
    .ale_i (ale_s),
    .mode_o(mode)
  );

  hba_access #(.AW(AW), .DW(DW)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hrst_i   (hrst_s),
    .mode_i   (mode),
    .cs_n_i   (cs_n_s),
    .ctl_a_i  (ctl_a_s),
    .ctl_b_i  (ctl_b_s),
    .ale_i    (ale_s),
    .addr_i   (addr_s),
    .data_i   (data_s),
    .rd_act_o (rd_act),
    .rd_addr_o(rd_addr),
    .wr_o     (wr),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  hba_regfile #(.AW(AW), .DW(DW), .RO_LAST(RO_LAST), .WO_FIRST(WO_FIRST)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr),
    .waddr_i(wr_addr),
    .wdata_i(wr_data),
    .raddr_i(rd_addr),
    .rdata_o(data_o)
  );

  assign data_oe_o = rd_act;

  assert_oe_needs_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !cs_n_s);

  assert_no_wr_unsel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_n_s && $past(cs_n_s)) |-> !wr);
endmodule

// File: tb/tb_host_bus_adapter.sv
module tb_host_bus_adapter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_rst = 1'b0;
  logic       cs_n = 1'b1;
  logic       ale = 1'b1;
  logic       ca = 1'b1;
  logic       cb = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [16];

  always #10 clk = ~clk;

  host_bus_adapter dut (
    .clk_i(clk), .rst_ni(rst_n), .host_rst_i(host_rst), .cs_ni(cs_n), .ale_i(ale),
    .ctl_a_i(ca), .ctl_b_i(cb), .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(oe)
  );

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a <= 4'd3)       return 8'hC0 | {4'h0, a};
    else if (a >= 4'd12) return 8'h00;
    else                 return mem[a];
  endfunction

  task automatic model_wr(input logic [3:0] a, input logic [7:0] d);
    if (a >= 4'd4 && a <= 4'd11) mem[a] = d;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic do_reset(input logic ale_lvl);
    @(negedge clk);
    rst_n = 1'b0; ale = ale_lvl; cs_n = 1'b1; ca = 1'b1; cb = 1'b1;
    hold(3);
    rst_n = 1'b1;
    hold(5);
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
  endtask

  // strobe-plus-direction style
  task automatic ds_wr(input logic [3:0] a, input logic [7:0] d, input logic sel);
    cs_n = !sel; addr = a; din = d; cb = 1'b0; hold(2);
    ca = 1'b0; hold(4);
    ca = 1'b1; hold(1);
    cs_n = 1'b1; cb = 1'b1; hold(4);
  endtask

  task automatic ds_rd(input logic [3:0] a, input string req);
    cs_n = 1'b0; addr = a; cb = 1'b1; hold(2);
    ca = 1'b0; hold(4);
    chk(req, {7'd0, oe}, 8'd1);
    chk(req, dout, exp_rd(a));
    ca = 1'b1; cs_n = 1'b1; hold(4);
  endtask

  // separate-strobe style
  task automatic rw_wr(input logic [3:0] a, input logic [7:0] d, input logic sel);
    cs_n = !sel; addr = a; din = d; hold(2);
    cb = 1'b0; hold(4);
    cb = 1'b1; hold(1);
    cs_n = 1'b1; hold(4);
  endtask

  task automatic rw_rd(input logic [3:0] a, input string req);
    cs_n = 1'b0; addr = a; hold(2);
    ca = 1'b0; hold(3);
    addr = ~a;  // later pin changes must be ignored (R5)
    hold(3);
    chk(req, {7'd0, oe}, 8'd1);
    chk(req, dout, exp_rd(a));
    ca = 1'b1; cs_n = 1'b1; hold(4);
  endtask

  // multiplexed style
  task automatic mx_addr(input logic [3:0] a);
    cs_n = 1'b0; addr = 4'($urandom()); din = {4'($urandom()), a};
    ale = 1'b1; hold(3);
    ale = 1'b0; hold(3);
  endtask

  task automatic mx_wr(input logic [3:0] a, input logic [7:0] d);
    mx_addr(a);
    din = d; cb = 1'b0; hold(4);
    cb = 1'b1; hold(1);
    cs_n = 1'b1; hold(4);
  endtask

  task automatic mx_rd(input logic [3:0] a, input string req);
    mx_addr(a);
    din = 8'($urandom()); ca = 1'b0; hold(4);
    chk(req, {7'd0, oe}, 8'd1);
    chk(req, dout, exp_rd(a));
    ca = 1'b1; cs_n = 1'b1; hold(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));

    // R1 reset state, strobe-plus-direction style (R2)
    do_reset(1'b1);
    chk("R1 oe idle", {7'd0, oe}, 8'd0);
    ds_rd(4'd5, "R1 rw loc reset");
    chk("R8 oe after read", {7'd0, oe}, 8'd0);
    for (int a = 0; a < 16; a++) begin
      d = 8'($urandom());
      ds_wr(4'(a), d, 1'b1);
      model_wr(4'(a), d);
    end
    for (int a = 0; a < 16; a++) ds_rd(4'(a), "R2 R7 readback");
    // write while deselected must not land (R8)
    ds_wr(4'd6, ~mem[6], 1'b0);
    ds_rd(4'd6, "R8 deselected write");
    // direction high with strobe writes nothing (R2)
    cs_n = 1'b0; addr = 4'd7; din = ~mem[7]; cb = 1'b1; hold(2);
    ca = 1'b0; hold(4); ca = 1'b1; hold(1); cs_n = 1'b1; hold(4);
    ds_rd(4'd7, "R2 read no write");

    // separate-strobe style (R3)
    do_reset(1'b0);
    for (int a = 0; a < 16; a++) begin
      d = 8'($urandom());
      rw_wr(4'(a), d, 1'b1);
      model_wr(4'(a), d);
    end
    for (int a = 0; a < 16; a++) rw_rd(4'(a), "R3 R5 readback");
    // read strobe with cs high must not drive (R8)
    cs_n = 1'b1; addr = 4'd4; hold(2); ca = 1'b0; hold(4);
    chk("R8 oe deselected", {7'd0, oe}, 8'd0);
    ca = 1'b1; hold(4);
    // write release and read start in the same cycle (R6)
    cs_n = 1'b0; addr = 4'd9; din = 8'h5A; hold(2);
    cb = 1'b0; hold(4);
    cb = 1'b1; ca = 1'b0; hold(1);
    din = 8'hFF; hold(4);
    model_wr(4'd9, 8'h5A);
    chk("R6 same-cycle read oe", {7'd0, oe}, 8'd1);
    chk("R6 same-cycle read data", dout, 8'h5A);
    ca = 1'b1; cs_n = 1'b1; hold(4);
    rw_rd(4'd9, "R6 single write");

    // multiplexed style (R4); starts from ale low after reset
    do_reset(1'b0);
    for (int a = 0; a < 16; a++) begin
      d = 8'($urandom());
      mx_wr(4'(a), d);
      model_wr(4'(a), d);
    end
    for (int a = 15; a >= 0; a--) mx_rd(4'(a), "R4 R7 readback");
    hold(20);
    mx_rd(4'd10, "R4 style kept");

    // host reset pin (R9): back to separate strobes with ale low
    host_rst = 1'b1; hold(5);
    chk("R9 oe idle", {7'd0, oe}, 8'd0);
    host_rst = 1'b0; hold(4);
    rw_wr(4'd11, 8'h3C, 1'b1);
    model_wr(4'd11, 8'h3C);
    rw_rd(4'd11, "R9 redetect");
    rw_rd(4'd2, "R9 R7 ro loc");

    finish_run();
  end
endmodule